// File: doc/BRIEF.md
# Flag-Setting ALU with Signed Shifter

This block is the 32-bit arithmetic and logic unit of a small load-store processor core. Each cycle it takes a first operand and either a second register operand or a 16-bit immediate, an operation select, a half-select bit, a flag-update bit and the current condition flags. It returns the result and the next value of the four condition flags: zero, negative, overflow and carry. Both outputs are registered, so a result appears one clock after its operands.

The unit builds its second operand from the immediate when asked to. The 16-bit constant is placed in the upper or lower half of the word. The other half is filled with zeros, except for AND, where it is filled with ones. For shifts the constant is sign-extended instead. The shifter reads a signed 6-bit amount. Positive values shift left and negative values shift right, either logically or arithmetically. Subtract-with-borrow keeps a cleared zero flag cleared, so that a 64-bit comparison can be done as two chained 32-bit subtractions.

Top module: `alu_flagged`

## Requirements
- R1: `op_i` selects the operation: 0 add, 1 add plus carry-in, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR, 7 shift. Add computes a+b and add-with-carry computes a+b+C, where C is `flags_i[0]`.
- R2: Subtract computes a + ~b + 1 and subtract-with-borrow computes a + ~b + C. For all four arithmetic operations, the carry flag becomes the carry out of bit 31.
- R3: When `use_imm_i`=1 and the operation is not a shift, the second operand is built from the immediate. `hsel_i`=1 puts `imm_i` in bits 31..16 and `hsel_i`=0 puts it in bits 15..0. The other half is 0x0000, or 0xFFFF when the operation is AND.
- R4: For an immediate shift, `imm_i` is sign-extended. The signed amount shifts left when positive or zero and right when negative, with magnitude 0..31. `hsel_i`=0 selects a logical shift and `hsel_i`=1 selects an arithmetic shift.
- R5: For a register shift, the signed 6-bit amount is {`opb_i`[31], `opb_i`[4:0]}. All other bits of `opb_i` have no effect.
- R6: The overflow flag is set for an arithmetic operation when both adder inputs (a and the possibly inverted b) have equal sign bits and the sign of the result differs. It is cleared for logic operations and shifts.
- R7: On a left shift, the carry flag is the last bit shifted out (0 for a shift by 0). Right shifts and logic operations clear the carry flag.
- R8: The negative flag equals bit 31 of the result. The zero flag is set exactly when the result is zero (see R9).
- R9: Subtract-with-borrow forces the zero flag to 0 when `flags_i[3]` is 0. Otherwise it sets the zero flag from the result as in R8.
- R10: When `fupd_i`=0, `flags_o` takes `flags_i` unchanged, while `res_o` still carries the result.
- R11: Both outputs are registered with one cycle of latency. A synchronous active-high `rst` clears `res_o` and `flags_o` to zero.

Flags are packed as {Z, N, V, C} in bits 3..0 of `flags_i` and `flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate constant |
| use_imm_i | input | 1 | 1 selects the immediate as the second operand |
| op_i | input | 3 | Operation select |
| hsel_i | input | 1 | Half select for immediates; logical/arithmetic select for shifts |
| fupd_i | input | 1 | 1 lets the flags update |
| flags_i | input | 4 | Current flags {Z,N,V,C} |
| res_o | output | 32 | Registered result |
| flags_o | output | 4 | Registered next flags {Z,N,V,C} |

## Verification
The result and flags of a stimulus become visible exactly one rising edge after it is applied, because each passes through a single output register. The bench drives inputs on the falling edge and compares both outputs on the next falling edge. One directed check also samples just before the capturing edge, to confirm that the outputs still hold the previous result there. Reset is checked the same way: it clears the outputs at the first rising edge where it is seen, even while live operands are applied.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_SHF  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic v;
        logic c;
    } alu_flags_t;

    function automatic logic is_arith(input alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) || (op == OP_SUBB);
    endfunction

    function automatic logic is_logic(input alu_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic inverts_b(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SUBB);
    endfunction

endpackage

// File: rtl/alu_opnd.sv
module alu_opnd
    import alu_flag_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  logic [DW-1:0] reg_b,
    input  logic [IW-1:0] imm,
    input  logic          use_imm,
    input  alu_op_e       op,
    input  logic          hsel,
    output logic [DW-1:0] opnd_b
);
    localparam int FW = DW - IW;

    logic [FW-1:0] fill;
    logic [DW-1:0] imm_word;

    always_comb begin
        fill = (op == OP_AND) ? {FW{1'b1}} : {FW{1'b0}};
        if (op == OP_SHF)
            imm_word = {{FW{imm[IW-1]}}, imm};
        else if (hsel)
            imm_word = {imm, fill};
        else
            imm_word = {fill, imm};
        opnd_b = use_imm ? imm_word : reg_b;
    end

endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_flag_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic          ovf
);
    logic [DW-1:0] bx;
    logic          ci;

    always_comb begin
        bx = inverts_b(op) ? ~b : b;
        unique case (op)
            OP_ADDC, OP_SUBB: ci = cin;
            OP_SUB:           ci = 1'b1;
            default:          ci = 1'b0;
        endcase
        {cout, sum} = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, ci};
        ovf = (a[DW-1] == bx[DW-1]) && (sum[DW-1] != a[DW-1]);
    end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int DW = 32,
    parameter int AW = $clog2(DW) + 1
) (
    input  logic [DW-1:0] a,
    input  logic [AW-1:0] amt,
    input  logic          arith,
    output logic [DW-1:0] res,
    output logic          cout
);
    logic [AW-1:0] mag;
    logic [DW:0]   lwide;

    always_comb begin
        mag   = amt[AW-1] ? (~amt + 1'b1) : amt;
        lwide = {1'b0, a} << mag;
        if (!amt[AW-1]) begin
            res  = lwide[DW-1:0];
            cout = lwide[DW];
        end else begin
            res  = arith ? DW'($signed(a) >>> mag) : (a >> mag);
            cout = 1'b0;
        end
    end

endmodule

// File: rtl/alu_flagged.sv
module alu_flagged
    import alu_flag_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    input  logic [IW-1:0] imm_i,
    input  logic          use_imm_i,
    input  logic [2:0]    op_i,
    input  logic          hsel_i,
    input  logic          fupd_i,
    input  logic [3:0]    flags_i,
    output logic [DW-1:0] res_o,
    output logic [3:0]    flags_o
);
    localparam int AW = $clog2(DW) + 1;

    alu_op_e       op;
    alu_flags_t    fin;
    alu_flags_t    fnew;
    logic [DW-1:0] b_eff;
    logic [AW-1:0] sh_amt;
    logic [DW-1:0] sum, sh_res, lg_res, res_d;
    logic          a_cout, a_ovf, sh_cout;

    assign op  = alu_op_e'(op_i);
    assign fin = alu_flags_t'(flags_i);

    alu_opnd #(.DW(DW), .IW(IW)) u_opnd (
        .reg_b   (opb_i),
        .imm     (imm_i),
        .use_imm (use_imm_i),
        .op      (op),
        .hsel    (hsel_i),
        .opnd_b  (b_eff)
    );

    alu_arith #(.DW(DW)) u_arith (
        .a    (opa_i),
        .b    (b_eff),
        .op   (op),
        .cin  (fin.c),
        .sum  (sum),
        .cout (a_cout),
        .ovf  (a_ovf)
    );

    assign sh_amt = {b_eff[DW-1], b_eff[AW-2:0]};

    alu_shift #(.DW(DW), .AW(AW)) u_shift (
        .a     (opa_i),
        .amt   (sh_amt),
        .arith (hsel_i),
        .res   (sh_res),
        .cout  (sh_cout)
    );

    always_comb begin
        unique case (op)
            OP_AND:  lg_res = opa_i & b_eff;
            OP_OR:   lg_res = opa_i | b_eff;
            default: lg_res = opa_i ^ b_eff;
        endcase
        if (is_arith(op))
            res_d = sum;
        else if (op == OP_SHF)
            res_d = sh_res;
        else
            res_d = lg_res;

        fnew.n = res_d[DW-1];
        fnew.z = ((op == OP_SUBB) && !fin.z) ? 1'b0 : (res_d == '0);
        fnew.v = is_arith(op) ? a_ovf : 1'b0;
        if (is_arith(op))
            fnew.c = a_cout;
        else if (op == OP_SHF)
            fnew.c = sh_cout;
        else
            fnew.c = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o   <= '0;
            flags_o <= '0;
        end else begin
            res_o   <= res_d;
            flags_o <= fupd_i ? fnew : flags_i;
        end
    end

endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk
    import alu_flag_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [2:0]    op_i,
    input logic          use_imm_i,
    input logic          fupd_i,
    input logic [3:0]    flags_i,
    input logic [DW-1:0] res_o,
    input logic [3:0]    flags_o
);
    // flags hold when update disabled
    p_hold_flags_r10: assert property (@(posedge clk) disable iff (rst)
        !fupd_i |=> (flags_o == $past(flags_i)));

    // N mirrors the sign of the result
    p_neg_sign_r8: assert property (@(posedge clk) disable iff (rst)
        fupd_i |=> (flags_o[2] == res_o[DW-1]));

    // Z reports zero result outside of subtract-with-borrow
    p_zero_result_r8: assert property (@(posedge clk) disable iff (rst)
        (fupd_i && op_i != 3'd3) |=> (flags_o[3] == (res_o == '0)));

    // subtract-with-borrow cannot raise a cleared Z
    p_sticky_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (fupd_i && op_i == 3'd3 && !flags_i[3]) |=> !flags_o[3]);

    // logic ops clear V and C
    p_logic_vc_r7: assert property (@(posedge clk) disable iff (rst)
        (fupd_i && (op_i == 3'd4 || op_i == 3'd5 || op_i == 3'd6)) |=> (flags_o[1:0] == 2'b00));

    // shifts never set V
    p_shift_novf_r6: assert property (@(posedge clk) disable iff (rst)
        (fupd_i && op_i == 3'd7) |=> !flags_o[1]);

    // reset clears both outputs
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (res_o == '0 && flags_o == 4'd0));

    logic unused_ok;
    assign unused_ok = use_imm_i;

endmodule

bind alu_flagged alu_flag_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op_i),
    .use_imm_i (use_imm_i),
    .fupd_i    (fupd_i),
    .flags_i   (flags_i),
    .res_o     (res_o),
    .flags_o   (flags_o)
);

// File: tb/sim_alu_flagged.sv
module sim_alu_flagged;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opa, opb;
    logic [15:0] imm;
    logic        use_imm, hsel, fupd;
    logic [2:0]  op;
    logic [3:0]  fin;
    logic [31:0] res;
    logic [3:0]  fout;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    alu_flagged u0 (
        .clk (clk), .rst (rst),
        .opa_i (opa), .opb_i (opb), .imm_i (imm), .use_imm_i (use_imm),
        .op_i (op), .hsel_i (hsel), .fupd_i (fupd), .flags_i (fin),
        .res_o (res), .flags_o (fout)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] im;
        logic        ui;
        logic [2:0]  op;
        logic        h;
        logic        f;
        logic [3:0]  fi;
        logic [31:0] er;
        logic [3:0]  ef;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 18;
    // flags {Z,N,V,C}
    localparam vec_t VEC [NV] = '{
        '{32'h7FFFFFFF, 32'h1,        16'h0,    1'b0, 3'd0, 1'b0, 1'b1, 4'h0, 32'h80000000, 4'h6, 8'd1},  // R1 add, V set
        '{32'hFFFFFFFF, 32'h0,        16'h0,    1'b0, 3'd1, 1'b0, 1'b1, 4'h1, 32'h00000000, 4'h9, 8'd1},  // R1 addc carry-in
        '{32'h5,        32'h5,        16'h0,    1'b0, 3'd2, 1'b0, 1'b1, 4'h0, 32'h00000000, 4'h9, 8'd2},  // R2 sub equal
        '{32'h3,        32'h5,        16'h0,    1'b0, 3'd2, 1'b0, 1'b1, 4'h0, 32'hFFFFFFFE, 4'h4, 8'd2},  // R2 sub borrow
        '{32'h7,        32'h7,        16'h0,    1'b0, 3'd3, 1'b0, 1'b1, 4'h1, 32'h00000000, 4'h1, 8'd9},  // R9 Z kept clear
        '{32'h7,        32'h6,        16'h0,    1'b0, 3'd3, 1'b0, 1'b1, 4'h8, 32'h00000000, 4'h9, 8'd9},  // R9 Z computed
        '{32'h12345678, 32'h0,        16'h0F0F, 1'b1, 3'd4, 1'b0, 1'b1, 4'h3, 32'h12340608, 4'h0, 8'd3},  // R3 and low, ones fill
        '{32'h00001111, 32'h0,        16'hABCD, 1'b1, 3'd5, 1'b1, 1'b1, 4'h0, 32'hABCD1111, 4'h4, 8'd3},  // R3 or high
        '{32'h0000FFFF, 32'h0,        16'hFFFF, 1'b1, 3'd6, 1'b0, 1'b1, 4'h0, 32'h00000000, 4'h8, 8'd8},  // R8 xor zero
        '{32'hC0000001, 32'h0,        16'h0001, 1'b1, 3'd7, 1'b0, 1'b1, 4'h0, 32'h80000002, 4'h5, 8'd7},  // R7 left, C = bit out
        '{32'h80000010, 32'h0,        16'hFFFC, 1'b1, 3'd7, 1'b0, 1'b1, 4'hF, 32'h08000001, 4'h0, 8'd4},  // R4 logical right
        '{32'h80000010, 32'h0,        16'hFFFC, 1'b1, 3'd7, 1'b1, 1'b1, 4'h0, 32'hF8000001, 4'h4, 8'd4},  // R4 arith right
        '{32'h00000004, 32'h8000FFFF, 16'h0,    1'b0, 3'd7, 1'b0, 1'b1, 4'h0, 32'h00000002, 4'h0, 8'd5},  // R5 reg amount -1
        '{32'h00000003, 32'h7FFFFFFF, 16'h0,    1'b0, 3'd7, 1'b0, 1'b1, 4'h0, 32'h80000000, 4'h5, 8'd5},  // R5 reg amount 31
        '{32'h0,        32'h0,        16'h0,    1'b0, 3'd0, 1'b0, 1'b0, 4'hA, 32'h00000000, 4'hA, 8'd10}, // R10 hold flags
        '{32'h5,        32'h0,        16'h0,    1'b1, 3'd7, 1'b0, 1'b1, 4'h0, 32'h00000005, 4'h0, 8'd4},  // R4 shift by zero
        '{32'h80000000, 32'h80000000, 16'h0,    1'b0, 3'd0, 1'b0, 1'b1, 4'h0, 32'h00000000, 4'hB, 8'd6},  // R6 neg overflow
        '{32'h1,        32'h5,        16'h0,    1'b0, 3'd3, 1'b0, 1'b1, 4'h9, 32'hFFFFFFFC, 4'h4, 8'd9}   // R9 nonzero subb
    };

    task automatic check(input string tag, input logic [31:0] gr, input logic [31:0] er,
                         input logic [3:0] gf, input logic [3:0] ef);
        n_chk++;
        if (gr !== er || gf !== ef) begin
            n_bad++;
            $display("FAIL %s: res=%h flags=%h expected res=%h flags=%h", tag, gr, gf, er, ef);
        end
    endtask

    task automatic drive(input vec_t v);
        opa = v.a; opb = v.b; imm = v.im; use_imm = v.ui;
        op = v.op; hsel = v.h; fupd = v.f; fin = v.fi;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(VEC[0]);
        @(posedge clk); @(negedge clk);
        check("R11 reset state", res, 32'h0, fout, 4'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            @(posedge clk); @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), res, VEC[i].er, fout, VEC[i].ef);
        end

        // R11 latency: previous result still held just before the capturing edge
        @(negedge clk);
        drive(VEC[0]);
        @(posedge clk); @(negedge clk);
        drive(VEC[7]);
        #8;
        check("R11 held before edge", res, VEC[0].er, fout, VEC[0].ef);
        @(posedge clk); @(negedge clk);
        check("R11 new after edge", res, VEC[7].er, fout, VEC[7].ef);

        // R5 upper bits of register amount ignored: same shift with clean amount
        drive('{32'h00000004, 32'h0000001F | 32'h80000000, 16'h0, 1'b0, 3'd7, 1'b0, 1'b1,
                4'h0, 32'h0, 4'h0, 8'd5});
        @(posedge clk); @(negedge clk);
        check("R5 clean amount", res, 32'h00000002, fout, 4'h0);

        // R3 AND high half fills low with ones
        drive('{32'hFFFF00FF, 32'h0, 16'h0F00, 1'b1, 3'd4, 1'b1, 1'b1, 4'h0, 32'h0, 4'h0, 8'd3});
        @(posedge clk); @(negedge clk);
        check("R3 and high", res, 32'h0F0000FF, fout, 4'h0);

        // R11 reset mid-run with live operands
        drive(VEC[1]);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R11 reset clears", res, 32'h0, fout, 4'h0);
        rst = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule